// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the mode sequencer of an on-chip clock generator. Each cycle it reads a two-bit clock-select field, an internal-reference select bit, a low-power bit and a debug-enable input. From these it picks one of six run modes. The mode is held in a state register. The block drives the control lines that the analog loop, the reference paths and the clock gating need: the output clock mux select, the loop enable, the loop reference-source select, the low-speed auxiliary clock enable, the low-power gate, and a status value that reports the loop multiplier.

A stop request moves the controller into a seventh state, stop, from any run mode. The mode that was active at that moment is saved. When the request is withdrawn, the saved mode comes back. A reset taken during stop clears the saved mode, so the controller starts again in the default internal-reference loop mode. Setting combinations that select no mode leave the current mode as it is.

States and transitions: RESET to ENG_INT; ENG_INT/ENG_EXT/BYP_INT/BYP_INT_LP/BYP_EXT/BYP_EXT_LP to any other run mode on a valid setting (DECODE); any run mode to STOP on a request (ENTER_STOP); STOP to the saved mode on release (RESTORE); any state to ENG_INT on reset.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode is ENG_INT (code 0). In that mode the outputs are out_sel=00, loop_en=1, ref_int=1, aux_clk_en=1, lp_gate=0 and loop_mult=512.
- R2: When not in stop, clk_sel=00 gives ENG_INT if int_ref_sel=1 and ENG_EXT (code 1) if int_ref_sel=0. ENG_EXT drives out_sel=00, loop_en=1, ref_int=0, aux_clk_en=1, lp_gate=0 and loop_mult=512.
- R3: clk_sel=01 with int_ref_sel=1 gives BYP_INT (code 2) when dbg_en=1 or low_pwr=0. BYP_INT drives out_sel=01, loop_en=1, ref_int=1, aux_clk_en=1, lp_gate=0 and loop_mult=0.
- R4: clk_sel=01 with int_ref_sel=1, dbg_en=0 and low_pwr=1 gives BYP_INT_LP (code 3). BYP_INT_LP drives out_sel=01, loop_en=0, ref_int=1, aux_clk_en=0, lp_gate=1 and loop_mult=0.
- R5: clk_sel=10 with int_ref_sel=0 gives BYP_EXT (code 4) when dbg_en=1 or low_pwr=0, and BYP_EXT_LP (code 5) when dbg_en=0 and low_pwr=1. Both drive out_sel=10, ref_int=0 and loop_mult=0. BYP_EXT drives loop_en=1, aux_clk_en=1, lp_gate=0. BYP_EXT_LP drives loop_en=0, aux_clk_en=0, lp_gate=1.
- R6: clk_sel=11, clk_sel=01 with int_ref_sel=0, and clk_sel=10 with int_ref_sel=1 leave the mode unchanged.
- R7: stop_req=1 in any run mode gives STOP (code 6) one cycle later. STOP drives out_sel=11, loop_en=0, ref_int=0, aux_clk_en=0, lp_gate=1 and loop_mult=0. Configuration inputs are ignored while in STOP.
- R8: With stop_req=0 in STOP, the next mode is the run mode that was active when STOP was entered, whatever the configuration inputs are at that time.
- R9: A reset during STOP leaves ENG_INT after the reset, and the pre-stop mode is not restored.
- R10: mode_code follows the codes above. mode_onehot has exactly bit mode_code set. Both change one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock-select field |
| int_ref_sel | input | 1 | 1 selects the internal reference |
| low_pwr | input | 1 | Low-power request bit |
| dbg_en | input | 1 | Debug interface enabled |
| stop_req | input | 1 | Stop-mode request |
| mode_code | output | 3 | Encoded current mode |
| mode_onehot | output | 7 | One-hot current mode |
| out_sel | output | 2 | Output mux: 00 loop, 01 internal ref, 10 external ref, 11 none |
| loop_en | output | 1 | Loop enable |
| ref_int | output | 1 | Loop/bypass reference is internal |
| aux_clk_en | output | 1 | Low-speed debug clock enable |
| lp_gate | output | 1 | Low-power gating active |
| loop_mult | output | 10 | Loop multiplier status, 0 when bypassed |

## Verification
The only register between the inputs and the outputs is the mode register. Every output is decoded from that register, so any effect of a configuration change or a stop request appears exactly one rising edge after it is applied. The bench changes inputs on a falling edge and samples on the next falling edge, so one rising edge lies between each stimulus and its check. A restore from stop also appears one edge after the release. The follow-up check on the next edge confirms that the mode then tracks the configuration, which shows the release edge itself took the saved mode and not the decoded one.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
    localparam int NUM_MODES = 7;
    localparam int MODE_W    = $clog2(NUM_MODES);

    typedef enum logic [MODE_W-1:0] {
        ENG_INT    = 3'd0,
        ENG_EXT    = 3'd1,
        BYP_INT    = 3'd2,
        BYP_INT_LP = 3'd3,
        BYP_EXT    = 3'd4,
        BYP_EXT_LP = 3'd5,
        STOP       = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        SRC_LOOP = 2'b00,
        SRC_IREF = 2'b01,
        SRC_EREF = 2'b10,
        SRC_NONE = 2'b11
    } src_e;
endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
    import clkmode_pkg::*;
(
    input  logic [1:0] clk_sel,
    input  logic       int_ref_sel,
    input  logic       low_pwr,
    input  logic       dbg_en,
    output mode_e      cfg_mode,
    output logic       cfg_ok
);
    logic lp_allowed;

    assign lp_allowed = low_pwr && !dbg_en;

    always_comb begin
        cfg_mode = ENG_INT;
        cfg_ok   = 1'b0;
        unique case (clk_sel)
            2'b00: begin
                cfg_ok   = 1'b1;
                cfg_mode = int_ref_sel ? ENG_INT : ENG_EXT;
            end
            2'b01: begin
                cfg_ok   = int_ref_sel;
                cfg_mode = lp_allowed ? BYP_INT_LP : BYP_INT;
            end
            2'b10: begin
                cfg_ok   = !int_ref_sel;
                cfg_mode = lp_allowed ? BYP_EXT_LP : BYP_EXT;
            end
            default: begin
                cfg_ok   = 1'b0;
                cfg_mode = ENG_INT;
            end
        endcase
    end
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
    import clkmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e cfg_mode,
    input  logic  cfg_ok,
    input  logic  stop_req,
    output mode_e mode_q
);
    mode_e mode_d;
    mode_e saved_q;
    mode_e saved_d;
    logic  in_run;

    assign in_run = (mode_q != STOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= ENG_INT;
            saved_q <= ENG_INT;
        end else begin
            mode_q  <= mode_d;
            saved_q <= saved_d;
        end
    end

    always_comb begin
        mode_d  = mode_q;
        saved_d = saved_q;
        unique case (mode_q)
            ENG_INT, ENG_EXT, BYP_INT, BYP_INT_LP, BYP_EXT, BYP_EXT_LP: begin
                if (stop_req) begin
                    mode_d  = STOP;
                    saved_d = mode_q;
                end else if (cfg_ok) begin
                    mode_d = cfg_mode;
                end
            end
            STOP: begin
                if (!stop_req) begin
                    mode_d = saved_q;
                end
            end
            default: begin
                mode_d  = ENG_INT;
                saved_d = ENG_INT;
            end
        endcase
    end

    // R7
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && stop_req) |=> (mode_q == STOP));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && stop_req) |=> (mode_q == STOP));

    // R6
    bad_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !stop_req && !cfg_ok) |=> $stable(mode_q));

    // R8
    restore_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && !stop_req) |=> (mode_q != STOP));
endmodule

// File: rtl/clkmode_outputs.sv
module clkmode_outputs
    import clkmode_pkg::*;
#(
    parameter int MULT   = 512,
    localparam int MULT_W = $clog2(MULT + 1)
) (
    input  mode_e                    mode_q,
    output logic [MODE_W-1:0]        mode_code,
    output logic [NUM_MODES-1:0]     mode_onehot,
    output logic [1:0]               out_sel,
    output logic                     loop_en,
    output logic                     ref_int,
    output logic                     aux_clk_en,
    output logic                     lp_gate,
    output logic [MULT_W-1:0]        loop_mult
);
    logic engaged;

    assign mode_code = mode_q;

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_onehot
        assign mode_onehot[g] = (mode_q == mode_e'(g));
    end

    always_comb begin
        out_sel    = SRC_NONE;
        loop_en    = 1'b0;
        ref_int    = 1'b0;
        aux_clk_en = 1'b0;
        lp_gate    = 1'b1;
        engaged    = 1'b0;
        unique case (mode_q)
            ENG_INT: begin
                out_sel = SRC_LOOP; loop_en = 1'b1; ref_int = 1'b1;
                aux_clk_en = 1'b1; lp_gate = 1'b0; engaged = 1'b1;
            end
            ENG_EXT: begin
                out_sel = SRC_LOOP; loop_en = 1'b1; ref_int = 1'b0;
                aux_clk_en = 1'b1; lp_gate = 1'b0; engaged = 1'b1;
            end
            BYP_INT: begin
                out_sel = SRC_IREF; loop_en = 1'b1; ref_int = 1'b1;
                aux_clk_en = 1'b1; lp_gate = 1'b0;
            end
            BYP_INT_LP: begin
                out_sel = SRC_IREF; loop_en = 1'b0; ref_int = 1'b1;
                aux_clk_en = 1'b0; lp_gate = 1'b1;
            end
            BYP_EXT: begin
                out_sel = SRC_EREF; loop_en = 1'b1; ref_int = 1'b0;
                aux_clk_en = 1'b1; lp_gate = 1'b0;
            end
            BYP_EXT_LP: begin
                out_sel = SRC_EREF; loop_en = 1'b0; ref_int = 1'b0;
                aux_clk_en = 1'b0; lp_gate = 1'b1;
            end
            STOP: begin
                out_sel = SRC_NONE; loop_en = 1'b0; ref_int = 1'b0;
                aux_clk_en = 1'b0; lp_gate = 1'b1;
            end
            default: begin
                out_sel = SRC_NONE;
            end
        endcase
    end

    assign loop_mult = engaged ? MULT_W'(MULT) : '0;

    // R10
    always_comb begin
        onehot_chk: assert ($onehot0(mode_onehot));
    end

    // R4
    always_comb begin
        lp_excl_chk: assert (!(loop_en && lp_gate));
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int MULT   = 512,
    localparam int MULT_W = $clog2(MULT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            clk_sel,
    input  logic                  int_ref_sel,
    input  logic                  low_pwr,
    input  logic                  dbg_en,
    input  logic                  stop_req,
    output logic [2:0]            mode_code,
    output logic [6:0]            mode_onehot,
    output logic [1:0]            out_sel,
    output logic                  loop_en,
    output logic                  ref_int,
    output logic                  aux_clk_en,
    output logic                  lp_gate,
    output logic [MULT_W-1:0]     loop_mult
);
    mode_e cfg_mode;
    logic  cfg_ok;
    mode_e mode_q;

    clkmode_decode u_decode (
        .clk_sel     (clk_sel),
        .int_ref_sel (int_ref_sel),
        .low_pwr     (low_pwr),
        .dbg_en      (dbg_en),
        .cfg_mode    (cfg_mode),
        .cfg_ok      (cfg_ok)
    );

    clkmode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .cfg_ok   (cfg_ok),
        .stop_req (stop_req),
        .mode_q   (mode_q)
    );

    clkmode_outputs #(.MULT(MULT)) u_out (
        .mode_q      (mode_q),
        .mode_code   (mode_code),
        .mode_onehot (mode_onehot),
        .out_sel     (out_sel),
        .loop_en     (loop_en),
        .ref_int     (ref_int),
        .aux_clk_en  (aux_clk_en),
        .lp_gate     (lp_gate),
        .loop_mult   (loop_mult)
    );
endmodule

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       int_ref_sel = 1'b1;
    logic       low_pwr = 1'b0;
    logic       dbg_en = 1'b0;
    logic       stop_req = 1'b0;
    logic [2:0] mode_code;
    logic [6:0] mode_onehot;
    logic [1:0] out_sel;
    logic       loop_en, ref_int, aux_clk_en, lp_gate;
    logic [9:0] loop_mult;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    clkmode_ctrl u_clkmode_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .int_ref_sel(int_ref_sel),
        .low_pwr(low_pwr), .dbg_en(dbg_en), .stop_req(stop_req),
        .mode_code(mode_code), .mode_onehot(mode_onehot), .out_sel(out_sel),
        .loop_en(loop_en), .ref_int(ref_int), .aux_clk_en(aux_clk_en),
        .lp_gate(lp_gate), .loop_mult(loop_mult)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected outputs per mode, from the requirement tables
    task automatic expect_mode(input string req, input int m);
        int e_sel, e_loop, e_ref, e_aux, e_lp, e_mult;
        case (m)
            0: begin e_sel = 0; e_loop = 1; e_ref = 1; e_aux = 1; e_lp = 0; e_mult = 512; end
            1: begin e_sel = 0; e_loop = 1; e_ref = 0; e_aux = 1; e_lp = 0; e_mult = 512; end
            2: begin e_sel = 1; e_loop = 1; e_ref = 1; e_aux = 1; e_lp = 0; e_mult = 0; end
            3: begin e_sel = 1; e_loop = 0; e_ref = 1; e_aux = 0; e_lp = 1; e_mult = 0; end
            4: begin e_sel = 2; e_loop = 1; e_ref = 0; e_aux = 1; e_lp = 0; e_mult = 0; end
            5: begin e_sel = 2; e_loop = 0; e_ref = 0; e_aux = 0; e_lp = 1; e_mult = 0; end
            default: begin e_sel = 3; e_loop = 0; e_ref = 0; e_aux = 0; e_lp = 1; e_mult = 0; end
        endcase
        chk(req, "mode_code", int'(mode_code), m);
        chk("R10", "mode_onehot", int'(mode_onehot), 1 << m);
        chk(req, "out_sel", int'(out_sel), e_sel);
        chk(req, "loop_en", int'(loop_en), e_loop);
        chk(req, "ref_int", int'(ref_int), e_ref);
        chk(req, "aux_clk_en", int'(aux_clk_en), e_aux);
        chk(req, "lp_gate", int'(lp_gate), e_lp);
        chk(req, "loop_mult", int'(loop_mult), e_mult);
    endtask

    // apply inputs after a falling edge, sample at the next falling edge
    task automatic apply(input logic [1:0] cs, input logic ir, input logic lp,
                         input logic dbg, input logic st);
        clk_sel = cs; int_ref_sel = ir; low_pwr = lp; dbg_en = dbg; stop_req = st;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R1", 0);
        clk_sel = 2'b11;
        rst_n = 1'b1;
        @(negedge clk);
        expect_mode("R1", 0);
    endtask

    task automatic t_engaged;
        apply(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R2", 1);
        apply(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_mode("R2", 0);
    endtask

    task automatic t_bypass_int;
        apply(2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_mode("R3", 2);
        apply(2'b01, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_mode("R3", 2);
        apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_mode("R4", 3);
        apply(2'b01, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_mode("R3", 2);
    endtask

    task automatic t_bypass_ext;
        apply(2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_mode("R5", 4);
        apply(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_mode("R5", 5);
        apply(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R5", 4);
    endtask

    task automatic t_invalid;
        apply(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_mode("R6", 4);
        apply(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R6", 4);
        apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_mode("R6", 4);
        apply(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_mode("R6", 4);
    endtask

    task automatic t_stop;
        apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_mode("R4", 3);
        apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b1);
        expect_mode("R7", 6);
        apply(2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_mode("R7", 6);
        apply(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_mode("R8", 3);
        @(negedge clk);
        expect_mode("R8", 1);
        apply(2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_mode("R7", 6);
        apply(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R8", 1);
    endtask

    task automatic t_stop_reset;
        apply(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_mode("R5", 4);
        apply(2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_mode("R7", 6);
        rst_n = 1'b0;
        @(negedge clk);
        stop_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        expect_mode("R9", 0);
        @(negedge clk);
        expect_mode("R9", 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_engaged;
        t_bypass_int;
        t_bypass_ext;
        t_invalid;
        t_stop;
        t_stop_reset;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule